// File: doc/BRIEF.md
# Envelope-Gated Three-Segment DAC Code Splitter

This block takes the signed 8-bit output word of a multi-bit quantizer and divides it among three binary-weighted sub-DACs with weights 1, 4 and 16. The two upper segments each hold a first-order digital sigma-delta stage. Each upper stage rounds what it receives to a multiple of its weight and passes its noise-shaped quantization error down to the next lower segment. The 1x segment takes the exact remainder, so the weighted sum of the three codes equals the input word in every sample.

A digital envelope detector watches the input amplitude and selects one of three levels. At level 0 only the 1x segment works. At level 1 the 1x and 4x segments work. At level 2 all three work. A bypassed segment outputs a zero code and has its DAC enable driven low. Its accumulator is held at zero, so it starts again from zero error when it comes back.

The level rises in the same sample whose magnitude calls for it. It falls one step at a time, and only after a decaying peak envelope has stayed under a lower threshold for a run of samples. The segment codes, the enables and the level all leave through one output register.

Top module: `seg_dac_splitter`

## Requirements
- R1: While reset is held and at the first edge after it, every segment code is 0, the enables are 3'b001 and the level is 0.
- R2: Codes, enables and level are registered and show the result for the sample presented at the previous rising clock edge.
- R3: In every output cycle, 16*code[2] + 4*code[1] + code[0] equals that cycle's input sample. Codes are signed 8-bit fields: code[i] sits at bits 8i+7 down to 8i of the code bus.
- R4: The level is coded 0, 1 or 2. Enable bit i (bit 0 is the 1x segment) is 1 exactly when i <= level. A disabled segment's code is 0. The 1x enable is always 1.
- R5: A sample whose magnitude is at least 64 puts level 2 on its own output. A magnitude of at least 16 gives at least level 1 on its own output.
- R6: The level drops by exactly one when the envelope integer part stays below 32 (from level 2) or below 8 (from level 1) for 16 consecutive samples. Any sample that fails the condition restarts the count, and so does any rise.
- R7: The envelope has 8 fraction bits. When the magnitude, scaled by 256, exceeds the envelope, it loads that value. Otherwise it loses its own value shifted right by 4. The drop test uses the updated envelope.
- R8: An active upper segment of weight W with accumulator a and incoming value u forms v = u + a and code c = floor((v + W/2) / W). Its accumulator becomes r = v - W*c, and it passes r - a downward. The 1x code is the value arriving at it. A bypassed upper segment passes u unchanged.
- R9: An upper segment's accumulator is cleared on every sample in which it is bypassed.
- R10: At level 0 the 1x code equals the input sample, including -128 and 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_i | input | 8 | Signed quantizer word, one per clock |
| seg_code_o | output | 24 | Three signed 8-bit segment codes, 1x segment in the low byte |
| seg_en_o | output | 3 | Sub-DAC enables, bit 0 for 1x |
| level_o | output | 2 | Current operating level |

## Verification
Quiet random words below 16 keep the splitter at level 0 and show that the 1x path is an exact copy. Mid-range and full-range random words exercise the error hand-off between the 4x and 16x stages, and the exact-sum check shows whether any error is lost. Bursts followed by silence, and silence broken by occasional mid-size words, separate a correct hold count and decay from a level that falls too early, too late or by two steps. Directed words at 15, 16, 63, 64, -64, 127 and -128 check that each rise threshold is inclusive and that the most negative code is handled.

// File: rtl/seg_split_pkg.sv
// Shared definitions for the segmented DAC splitter.
// Assumes exactly three segments; the level code doubles as the index of
// the highest active segment.
package seg_split_pkg;
    localparam int NUM_SEG = 3;
    localparam int LVL_W   = 2;

    typedef enum logic [LVL_W-1:0] {
        LVL_SMALL = 2'd0,
        LVL_MID   = 2'd1,
        LVL_FULL  = 2'd2
    } level_t;
endpackage

// File: rtl/seg_envelope.sv
// Envelope detector and level controller.
// Tracks the peak of |sample| with exponential decay. Raises the level at
// once when a sample needs it, and lowers it one step after HOLD_LEN
// consecutive samples with the envelope under the drop threshold.
// Assumes TH_*_DN <= TH_*_UP so that a drop never contradicts a rise.
module seg_envelope
    import seg_split_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FRAC_W     = 8,
    parameter int DECAY_SH   = 4,
    parameter int TH_MID_UP  = 16,
    parameter int TH_FULL_UP = 64,
    parameter int TH_MID_DN  = 8,
    parameter int TH_FULL_DN = 32,
    parameter int HOLD_LEN   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [DATA_W-1:0] sample_i,
    output level_t                   level_nxt_o,
    output level_t                   level_q_o
);
    localparam int ENV_W = DATA_W + FRAC_W;
    localparam int CNT_W = $clog2(HOLD_LEN + 1);

    logic [DATA_W-1:0] mag;
    logic [ENV_W-1:0]  mag_fx, env_q, env_nxt;
    logic [DATA_W-1:0] env_int;
    logic [CNT_W-1:0]  cnt_q, cnt_nxt;
    level_t            need, lvl_q, lvl_nxt;
    logic              below;

    // Magnitude of the incoming word; -2^(DATA_W-1) maps to 2^(DATA_W-1).
    always_comb begin
        mag    = sample_i[DATA_W-1] ? DATA_W'(-sample_i) : DATA_W'(sample_i);
        mag_fx = {mag, {FRAC_W{1'b0}}};
    end

    // Peak hold with decay, and the level the current sample asks for.
    always_comb begin
        env_nxt = (mag_fx > env_q) ? mag_fx : (env_q - (env_q >> DECAY_SH));
        env_int = env_nxt[ENV_W-1:FRAC_W];
        if (mag >= DATA_W'(TH_FULL_UP))     need = LVL_FULL;
        else if (mag >= DATA_W'(TH_MID_UP)) need = LVL_MID;
        else                                need = LVL_SMALL;
        case (lvl_q)
            LVL_FULL: below = env_int < DATA_W'(TH_FULL_DN);
            LVL_MID:  below = env_int < DATA_W'(TH_MID_DN);
            default:  below = 1'b0;
        endcase
    end

    // Level decision: immediate rise, held single-step fall.
    always_comb begin
        lvl_nxt = lvl_q;
        cnt_nxt = '0;
        if (need > lvl_q) begin
            lvl_nxt = need;
        end else if (below) begin
            if (cnt_q == CNT_W'(HOLD_LEN - 1)) begin
                lvl_nxt = level_t'(lvl_q - 2'd1);
            end else begin
                cnt_nxt = cnt_q + 1'b1;
            end
        end
    end

    // Envelope, hold counter and level registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            env_q <= '0;
            cnt_q <= '0;
            lvl_q <= LVL_SMALL;
        end else begin
            env_q <= env_nxt;
            cnt_q <= cnt_nxt;
            lvl_q <= lvl_nxt;
        end
    end

    assign level_nxt_o = lvl_nxt;
    assign level_q_o   = lvl_q;

    // R5: a full-scale-range sample puts the level at the top on the next edge.
    p_rise_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mag >= DATA_W'(TH_FULL_UP)) |=> (lvl_q == LVL_FULL));

    // R6: any fall is a single step.
    p_fall_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q < $past(lvl_q)) |-> (lvl_q == level_t'($past(lvl_q) - 2'd1)));

    // R6: the hold counter never reaches its length.
    p_hold_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(HOLD_LEN));
endmodule

// File: rtl/seg_sd_stage.sv
// First-order error-feedback stage for one upper segment.
// When active, rounds (incoming value + stored error) to a multiple of
// 2^SHIFT, keeps the new error and hands the difference of errors down.
// When bypassed, outputs a zero code, forwards its input and clears its
// error. Assumes SHIFT >= 1 and INT_W large enough for input plus error.
module seg_sd_stage #(
    parameter int INT_W = 10,
    parameter int SHIFT = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    active_i,
    input  logic signed [INT_W-1:0] resid_i,
    output logic signed [INT_W-1:0] code_o,
    output logic signed [INT_W-1:0] resid_o
);
    localparam int HALF = 1 << (SHIFT - 1);
    localparam logic signed [INT_W-1:0] HALF_V = INT_W'(HALF);

    logic signed [INT_W-1:0] acc_q, acc_nxt, v, q, r;

    // Rounding quantizer with error feedback.
    always_comb begin
        v = resid_i + acc_q;
        q = (v + HALF_V) >>> SHIFT;
        r = v - (q <<< SHIFT);
        if (active_i) begin
            code_o  = q;
            resid_o = r - acc_q;
            acc_nxt = r;
        end else begin
            code_o  = '0;
            resid_o = resid_i;
            acc_nxt = '0;
        end
    end

    // Stored quantization error.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_nxt;
    end

    // R8: stored error stays within half a weight.
    p_acc_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q >= -HALF_V) && (acc_q < HALF_V));

    // R9: a bypassed stage holds zero error afterwards.
    p_acc_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (acc_q == '0));
endmodule

// File: rtl/seg_dac_splitter.sv
// Top of the envelope-gated segmented DAC splitter.
// Chains the upper sigma-delta stages from the heaviest weight down; the
// 1x segment takes what remains. Segment i is active when i <= level.
// Codes, enables and level leave through one register stage.
module seg_dac_splitter
    import seg_split_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int SEG_SHIFT  = 2,
    parameter int FRAC_W     = 8,
    parameter int DECAY_SH   = 4,
    parameter int TH_MID_UP  = 16,
    parameter int TH_FULL_UP = 64,
    parameter int TH_MID_DN  = 8,
    parameter int TH_FULL_DN = 32,
    parameter int HOLD_LEN   = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [DATA_W-1:0]           sample_i,
    output logic [NUM_SEG*DATA_W-1:0]   seg_code_o,
    output logic [NUM_SEG-1:0]          seg_en_o,
    output logic [LVL_W-1:0]            level_o
);
    localparam int INT_W = DATA_W + 2;
    localparam int SUM_W = DATA_W + SEG_SHIFT * (NUM_SEG - 1) + 2;

    level_t                   lvl_nxt, lvl_q;
    logic [NUM_SEG-1:0]       active;
    logic signed [INT_W-1:0]  resid [NUM_SEG+1];
    logic signed [INT_W-1:0]  code_c [NUM_SEG];
    logic signed [DATA_W-1:0] code_q [NUM_SEG];
    logic [NUM_SEG-1:0]       en_q;

    seg_envelope #(
        .DATA_W(DATA_W), .FRAC_W(FRAC_W), .DECAY_SH(DECAY_SH),
        .TH_MID_UP(TH_MID_UP), .TH_FULL_UP(TH_FULL_UP),
        .TH_MID_DN(TH_MID_DN), .TH_FULL_DN(TH_FULL_DN),
        .HOLD_LEN(HOLD_LEN)
    ) env_i (
        .clk(clk), .rst_n(rst_n), .sample_i(DATA_W'(signed'(sample_i))),
        .level_nxt_o(lvl_nxt), .level_q_o(lvl_q)
    );

    // Top of the chain receives the sign-extended input word.
    assign resid[NUM_SEG] = INT_W'(signed'(sample_i));

    for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
        // Segment i works when the new level reaches it.
        assign active[i] = (LVL_W'(i) <= lvl_nxt);

        if (i == 0) begin : g_base
            // The unit segment absorbs the exact remainder.
            assign code_c[i] = resid[i+1];
            assign resid[i]  = '0;
        end else begin : g_upper
            seg_sd_stage #(
                .INT_W(INT_W), .SHIFT(SEG_SHIFT * i)
            ) stage_i (
                .clk(clk), .rst_n(rst_n), .active_i(active[i]),
                .resid_i(resid[i+1]), .code_o(code_c[i]),
                .resid_o(resid[i])
            );
        end

        // Output register for this segment's code and enable.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                code_q[i] <= '0;
                en_q[i]   <= (i == 0);
            end else begin
                code_q[i] <= DATA_W'(code_c[i]);
                en_q[i]   <= active[i];
            end
        end

        assign seg_code_o[i*DATA_W +: DATA_W] = code_q[i];

        // R4: a disabled segment carries a zero code.
        p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !en_q[i] |-> (code_q[i] == '0));
    end

    assign seg_en_o = en_q;
    assign level_o  = lvl_q;

    // Weighted sum of the registered codes, used only by the check below.
    logic signed [SUM_W-1:0] chk_sum;
    always_comb begin
        chk_sum = '0;
        for (int k = 0; k < NUM_SEG; k++) begin
            chk_sum = chk_sum + (SUM_W'(code_q[k]) <<< (SEG_SHIFT * k));
        end
    end

    // Marks that the output register holds a post-reset sample.
    logic primed_q;
    always_ff @(posedge clk) begin
        if (!rst_n) primed_q <= 1'b0;
        else        primed_q <= 1'b1;
    end

    // R3: codes rebuild the previous sample exactly.
    p_sum_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q |-> (chk_sum == SUM_W'(signed'($past(sample_i)))));

    // R4: the unit segment is never switched off.
    p_base_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
        en_q[0]);
endmodule

// File: tb/seg_dac_splitter_tb_top.sv
module seg_dac_splitter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sample_i = '0;
    logic [23:0] seg_code_o;
    logic [2:0]  seg_en_o;
    logic [1:0]  level_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // Reference state built from the requirements.
    int m_env = 0, m_lvl = 0, m_cnt = 0;
    int m_acc [3];
    int m_code [3];
    int m_in = 0;

    always #2.5 clk = ~clk;

    seg_dac_splitter dut_i (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i),
        .seg_code_o(seg_code_o), .seg_en_o(seg_en_o), .level_o(level_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int code_of(input int i);
        return int'($signed(seg_code_o[i*8 +: 8]));
    endfunction

    task automatic report;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    // R7, R6, R5, R8, R9 reference step for one sample.
    task automatic model_step(input int x);
        int mag, need, ei, u, w, v, c, r;
        bit low;
        mag = (x < 0) ? -x : x;
        m_env = ((mag << 8) > m_env) ? (mag << 8) : (m_env - (m_env >> 4));
        need = (mag >= 64) ? 2 : (mag >= 16) ? 1 : 0;
        ei = m_env >> 8;
        low = (m_lvl == 2) ? (ei < 32) : (m_lvl == 1) ? (ei < 8) : 1'b0;
        if (need > m_lvl) begin
            m_lvl = need; m_cnt = 0;
        end else if (low) begin
            if (m_cnt == 15) begin m_lvl--; m_cnt = 0; end
            else m_cnt++;
        end else m_cnt = 0;
        u = x;
        for (int i = 2; i >= 1; i--) begin
            if (i <= m_lvl) begin
                w = 1 << (2 * i);
                v = u + m_acc[i];
                c = (v + w / 2) >>> (2 * i);
                r = v - c * w;
                m_code[i] = c;
                u = r - m_acc[i];
                m_acc[i] = r;
            end else begin
                m_code[i] = 0;
                m_acc[i] = 0;
            end
        end
        m_code[0] = u;
        m_in = x;
    endtask

    // Compare the outputs for the sample applied one edge earlier (R2).
    task automatic check_outputs;
        int sum;
        for (int i = 0; i < 3; i++) begin
            chk(code_of(i) == m_code[i], $sformatf("R2 R8 R9 code[%0d]", i), code_of(i), m_code[i]);
            chk(seg_en_o[i] == (i <= m_lvl), $sformatf("R4 enable[%0d]", i), seg_en_o[i], (i <= m_lvl));
        end
        chk(int'(level_o) == m_lvl, "R6 R7 level", level_o, m_lvl);
        sum = 16 * code_of(2) + 4 * code_of(1) + code_of(0);
        chk(sum == m_in, "R3 weighted sum", sum, m_in);
        if (m_lvl == 0) chk(code_of(0) == m_in, "R10 unit passthrough", code_of(0), m_in);
    endtask

    task automatic drive(input int x);
        @(negedge clk);
        check_outputs();
        sample_i = 8'(x);
        model_step(x);
    endtask

    task automatic drive_rand(input int n, input int amp);
        for (int k = 0; k < n; k++) begin
            int x;
            x = int'($urandom_range(2 * amp)) - amp;
            if (x > 127) x = 127;
            drive(x);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        report();
    end

    initial begin
        void'($urandom(32'd24681));
        for (int i = 0; i < 3; i++) begin m_acc[i] = 0; m_code[i] = 0; end
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(seg_code_o == '0, "R1 codes", seg_code_o, 0);
        chk(seg_en_o == 3'b001, "R1 enables", seg_en_o, 1);
        chk(level_o == 2'd0, "R1 level", level_o, 0);
        rst_n = 1'b1;
        sample_i = 8'd0;
        model_step(0);

        // Quiet signal: level 0 only.
        drive_rand(300, 15);
        drive(15); drive(-15);
        @(negedge clk);
        chk(level_o == 2'd0, "R5 15 stays small", level_o, 0);
        sample_i = 8'd0; model_step(0);
        drive(-128);
        @(negedge clk);
        chk(level_o == 2'd2, "R5 -128 rises to full", level_o, 2);
        check_outputs();
        sample_i = 8'd0; model_step(0);

        // Decay back down, then threshold corners.
        repeat (120) drive(0);
        drive(16);
        @(negedge clk);
        chk(level_o == 2'd1, "R5 16 rises to mid", level_o, 1);
        check_outputs();
        sample_i = 8'd63; model_step(63);
        @(negedge clk);
        chk(level_o == 2'd1, "R5 63 stays mid", level_o, 1);
        check_outputs();
        sample_i = 8'd64; model_step(64);
        @(negedge clk);
        chk(level_o == 2'd2, "R5 64 rises to full", level_o, 2);
        check_outputs();
        sample_i = 8'(-64); model_step(-64);

        // Mid and full random ranges.
        drive_rand(600, 60);
        drive_rand(600, 128);
        drive(127); drive(-128); drive(127);

        // Bursts then silence, and silence broken by medium words.
        for (int b = 0; b < 20; b++) begin
            drive_rand(10, 128);
            repeat (int'($urandom_range(60))) drive(0);
            for (int k = 0; k < 30; k++) drive((k % 9 == 0) ? 40 : 0);
            repeat (int'($urandom_range(40))) drive(int'($urandom_range(6)) - 3);
        end
        repeat (100) drive(0);
        @(negedge clk);
        check_outputs();
        chk(level_o == 2'd0, "R6 settles to small", level_o, 0);
        done = 1'b1;
        report();
    end
endmodule